// File: doc/BRIEF.md
# Lane Alignment Sequence Checker

This block watches one receive lane after 8b/10b decoding. Its input is one octet per valid cycle with a flag that marks control characters. It finds the start of the lane alignment sequence and follows the multiframe boundaries, using a programmed octet-per-frame count and frames-per-multiframe count. The marker control characters must sit at fixed places. The block flags each marker that is missing or in the wrong place.

During the second multiframe it stores the 14-octet link configuration record. It decodes the record into parameter outputs and adds 1 back to the fields that are sent as value minus one. It then sums the decoded fields and compares that sum with the received checksum octet. It also compares the used bits of the record against an expected record given on an input port.

User data starts at the first multiframe boundary that does not carry K28.0. At that point the block pulses a completion strobe and checks that the sequence was between 4 and 256 multiframes long. All error flags are sticky until reset. After completion the block stays idle until the next reset.

Top module: `lane_align_chk`

## Requirements
- R1: After reset all outputs are 0. The block stays in a search state and ignores every octet until it sees 0x1C with the control flag set. A 0x1C without the flag, or any other control character, starts nothing and sets no flag. The first flagged 0x1C is octet 0 of multiframe 0.
- R2: A multiframe is `frm_octets * mf_frames` octets long. Its last octet must be 0x7C with the control flag set. If that octet is anything else, or if a flagged 0x7C appears at any other position, `err_end` is set.
- R3: A flagged 0x1C at any position other than octet 0 of a multiframe sets `err_start`.
- R4: Octet 1 of multiframe 1 must be a flagged 0x9C. If it is anything else, or if a flagged 0x9C appears anywhere else, `err_cfgmark` is set.
- R5: Octets 2 to 15 of multiframe 1 are stored as record octets 0 to 13, in that order.
- R6: Record layout: octet 0 = device id[7:0]. Octet 1 = adjust steps[7:4], bank id[3:0]. Octet 2 = adjust direction bit 6, phase request bit 5, lane id[4:0]. Octet 3 = scrambling bit 7, lanes-1[4:0]. Octet 4 = octets-per-frame-1. Octet 5 = frames-per-multiframe-1[4:0]. Octet 6 = converters-1. Octet 7 = control bits[7:6], resolution-1[4:0]. Octet 8 = subclass[7:5], bits-per-sample-1[4:0]. Octet 9 = version[7:5], samples-1[4:0]. Octet 10 = high-density bit 7, control words[4:0]. Octets 11 and 12 are reserved. Octet 13 = checksum. The minus-one fields are output with 1 added.
- R7: The expected checksum is the mod-256 sum of the raw field values of octets 0 to 10, with each field taken on its own. Reserved octets and unused bits are not part of the sum. If the sum differs from record octet 13, `err_sum` is set.
- R8: `err_param` is set when any used bit of record octets 0 to 10 differs from the same bit of `exp_rec`. Octet i of `exp_rec` is at bits [8i+7:8i]. Reserved octets and unused bits have no effect on this flag.
- R9: When a multiframe boundary octet is not a flagged 0x1C, `done` is high for exactly one cycle, in the cycle after that octet. At the same time `cfg_valid` rises and the decoded outputs are loaded. Both then hold until reset.
- R10: When `done` is asserted, `err_len` is set if the number of completed multiframes is below 4 or above 256.
- R11: All error flags are sticky until reset. `err_sum` and `err_param` are evaluated only when at least two multiframes have completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Octet valid this cycle |
| in_data | input | 8 | Decoded octet |
| in_ctrl | input | 1 | Octet is a control character |
| frm_octets | input | 9 | Octets per frame (1 to 256) |
| mf_frames | input | 6 | Frames per multiframe (1 to 32) |
| exp_rec | input | 112 | Expected record, octet i at bits [8i+7:8i] |
| done | output | 1 | One-cycle completion strobe |
| cfg_valid | output | 1 | Decoded outputs are valid |
| err_start | output | 1 | Misplaced start marker |
| err_end | output | 1 | Missing or misplaced end marker |
| err_cfgmark | output | 1 | Missing or misplaced record marker |
| err_sum | output | 1 | Checksum mismatch |
| err_param | output | 1 | Record differs from expected |
| err_len | output | 1 | Sequence length out of range |
| dev_id | output | 8 | Device id |
| bank_id | output | 4 | Bank id |
| adj_steps | output | 4 | Adjustment step count |
| adj_delay | output | 1 | Adjustment direction (1 = delay) |
| phase_req | output | 1 | Phase adjust request |
| lane_id | output | 5 | Lane id |
| scramble | output | 1 | Scrambling enabled |
| lane_cnt | output | 6 | Lanes per link (1 to 32) |
| frame_len | output | 9 | Octets per frame (1 to 256) |
| mf_len | output | 6 | Frames per multiframe (1 to 32) |
| conv_cnt | output | 9 | Converters (1 to 256) |
| ctl_bits | output | 2 | Control bits per sample |
| conv_res | output | 6 | Converter resolution (1 to 32) |
| subclass | output | 3 | Device subclass |
| sample_bits | output | 6 | Bits per sample (1 to 32) |
| version | output | 3 | Protocol version |
| spc | output | 6 | Samples per converter per frame (1 to 32) |
| hi_density | output | 1 | High-density format |
| ctl_words | output | 5 | Control words per frame |

## Verification
On every cycle, the assertions check these rules:
- `done` is a single-cycle pulse.
- Error flags never clear before reset.
- Length, checksum and parameter errors appear only together with `done`.
- The decoded outputs hold steady once `cfg_valid` is high.
- The multiframe counter never moves backwards during a sequence.

Other behaviour can only be shown by the bench's scenarios, which work out expected values from the record layout:
- which marker position raises which flag;
- the field-wise checksum value;
- that the minus-one fields are restored, including 256 converters;
- that reserved octets and unused bits are ignored;
- the length limits at 3, 256 and 257 multiframes.

// File: rtl/lac_pkg.sv
package lac_pkg;
  localparam int OCT_W      = 8;
  localparam int REC_OCTETS = 14;
  localparam int CMP_OCTETS = 11;
  localparam int SUM_IDX    = 13;
  localparam int REC_OFS    = 2;

  localparam logic [OCT_W-1:0] K_START = 8'h1C;
  localparam logic [OCT_W-1:0] K_END   = 8'h7C;
  localparam logic [OCT_W-1:0] K_CFG   = 8'h9C;

  typedef logic [REC_OCTETS-1:0][OCT_W-1:0] rec_t;

  typedef struct packed {
    logic [7:0] dev_id;
    logic [3:0] bank_id;
    logic [3:0] adj_steps;
    logic       adj_delay;
    logic       phase_req;
    logic [4:0] lane_id;
    logic       scramble;
    logic [5:0] lane_cnt;
    logic [8:0] frame_len;
    logic [5:0] mf_len;
    logic [8:0] conv_cnt;
    logic [1:0] ctl_bits;
    logic [5:0] conv_res;
    logic [2:0] subclass;
    logic [5:0] sample_bits;
    logic [2:0] version;
    logic [5:0] spc;
    logic       hi_density;
    logic [4:0] ctl_words;
  } cfg_t;

  // Mask of the bits that carry a field in each compared record octet.
  function automatic logic [OCT_W-1:0] used_mask(input int idx);
    case (idx)
      2:       used_mask = 8'h7F;
      3:       used_mask = 8'h9F;
      5:       used_mask = 8'h1F;
      7:       used_mask = 8'hDF;
      10:      used_mask = 8'h9F;
      default: used_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/lac_mf_tracker.sv
module lac_mf_tracker #(
  parameter int PW = 15,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          adv,
  input  logic [PW-1:0] mf_octets,
  output logic [PW-1:0] pos,
  output logic [CW-1:0] mf_idx,
  output logic          at_last
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  assign at_last = (pos == mf_octets - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      mf_idx <= '0;
    end else if (start) begin
      pos    <= PW'(1);
      mf_idx <= '0;
    end else if (adv) begin
      if (at_last) begin
        pos <= '0;
        if (mf_idx != CNT_MAX) mf_idx <= mf_idx + CW'(1);
      end else begin
        pos <= pos + PW'(1);
      end
    end
  end

  // R2: the multiframe counter only moves forward within a sequence
  a_r2_mf_monotonic: assert property (@(posedge clk) disable iff (rst)
    !start |=> mf_idx >= $past(mf_idx));
endmodule

// File: rtl/lac_rec_decode.sv
module lac_rec_decode
  import lac_pkg::*;
(
  input  rec_t       rec,
  output cfg_t       cfg,
  output logic [7:0] sum
);
  logic unused_rec;
  assign unused_rec = ^{rec[2][7], rec[3][6:5], rec[5][7:5], rec[7][5],
                        rec[10][6:5], rec[11], rec[12], rec[13]};

  always_comb begin
    cfg.dev_id      = rec[0];
    cfg.adj_steps   = rec[1][7:4];
    cfg.bank_id     = rec[1][3:0];
    cfg.adj_delay   = rec[2][6];
    cfg.phase_req   = rec[2][5];
    cfg.lane_id     = rec[2][4:0];
    cfg.scramble    = rec[3][7];
    cfg.lane_cnt    = {1'b0, rec[3][4:0]} + 6'd1;
    cfg.frame_len   = {1'b0, rec[4]} + 9'd1;
    cfg.mf_len      = {1'b0, rec[5][4:0]} + 6'd1;
    cfg.conv_cnt    = {1'b0, rec[6]} + 9'd1;
    cfg.ctl_bits    = rec[7][7:6];
    cfg.conv_res    = {1'b0, rec[7][4:0]} + 6'd1;
    cfg.subclass    = rec[8][7:5];
    cfg.sample_bits = {1'b0, rec[8][4:0]} + 6'd1;
    cfg.version     = rec[9][7:5];
    cfg.spc         = {1'b0, rec[9][4:0]} + 6'd1;
    cfg.hi_density  = rec[10][7];
    cfg.ctl_words   = rec[10][4:0];
  end

  // Field-wise sum of the raw (as transmitted) values, modulo 256.
  always_comb begin
    sum = rec[0]
        + {4'd0, rec[1][7:4]} + {4'd0, rec[1][3:0]}
        + {7'd0, rec[2][6]}   + {7'd0, rec[2][5]}   + {3'd0, rec[2][4:0]}
        + {7'd0, rec[3][7]}   + {3'd0, rec[3][4:0]}
        + rec[4]
        + {3'd0, rec[5][4:0]}
        + rec[6]
        + {6'd0, rec[7][7:6]} + {3'd0, rec[7][4:0]}
        + {5'd0, rec[8][7:5]} + {3'd0, rec[8][4:0]}
        + {5'd0, rec[9][7:5]} + {3'd0, rec[9][4:0]}
        + {7'd0, rec[10][7]}  + {3'd0, rec[10][4:0]};
  end
endmodule

// File: rtl/lac_param_cmp.sv
module lac_param_cmp
  import lac_pkg::*;
(
  input  rec_t got,
  input  rec_t expv,
  output logic mismatch
);
  logic [CMP_OCTETS-1:0] diff;
  logic unused_tail;
  assign unused_tail = ^{got[REC_OCTETS-1:CMP_OCTETS], expv[REC_OCTETS-1:CMP_OCTETS]};

  for (genvar i = 0; i < CMP_OCTETS; i++) begin : g_oct
    localparam logic [OCT_W-1:0] MASK = used_mask(i);
    assign diff[i] = |((got[i] ^ expv[i]) & MASK);
  end

  assign mismatch = |diff;
endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk
  import lac_pkg::*;
#(
  parameter int FW     = 9,
  parameter int KW     = 6,
  parameter int CW     = 9,
  parameter int MF_MIN = 4,
  parameter int MF_MAX = 256
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [7:0]                  in_data,
  input  logic                        in_ctrl,
  input  logic [FW-1:0]               frm_octets,
  input  logic [KW-1:0]               mf_frames,
  input  logic [REC_OCTETS*OCT_W-1:0] exp_rec,
  output logic                        done,
  output logic                        cfg_valid,
  output logic                        err_start,
  output logic                        err_end,
  output logic                        err_cfgmark,
  output logic                        err_sum,
  output logic                        err_param,
  output logic                        err_len,
  output logic [7:0]                  dev_id,
  output logic [3:0]                  bank_id,
  output logic [3:0]                  adj_steps,
  output logic                        adj_delay,
  output logic                        phase_req,
  output logic [4:0]                  lane_id,
  output logic                        scramble,
  output logic [5:0]                  lane_cnt,
  output logic [8:0]                  frame_len,
  output logic [5:0]                  mf_len,
  output logic [8:0]                  conv_cnt,
  output logic [1:0]                  ctl_bits,
  output logic [5:0]                  conv_res,
  output logic [2:0]                  subclass,
  output logic [5:0]                  sample_bits,
  output logic [2:0]                  version,
  output logic [5:0]                  spc,
  output logic                        hi_density,
  output logic [4:0]                  ctl_words
);
  localparam int PW  = FW + KW;
  localparam int RIW = $clog2(REC_OCTETS);

  typedef enum logic [1:0] {ST_SEARCH, ST_RUN, ST_FIN} state_t;
  state_t state;

  rec_t          rec;
  cfg_t          dec, cfg_q;
  logic [7:0]    sum;
  logic          mism;
  logic [PW-1:0] mf_octets, pos, rofs;
  logic [CW-1:0] mf_idx;
  logic          at_last, start, adv;
  logic          is_start, is_end, is_cfg, in_rec;

  assign mf_octets = PW'(frm_octets) * PW'(mf_frames);
  assign is_start  = in_ctrl && (in_data == K_START);
  assign is_end    = in_ctrl && (in_data == K_END);
  assign is_cfg    = in_ctrl && (in_data == K_CFG);
  assign start     = (state == ST_SEARCH) && in_valid && is_start;
  assign adv       = (state == ST_RUN) && in_valid;
  assign rofs      = pos - PW'(REC_OFS);
  assign in_rec    = (mf_idx == CW'(1)) && (pos >= PW'(REC_OFS))
                  && (pos < PW'(REC_OFS + REC_OCTETS));

  lac_mf_tracker #(.PW(PW), .CW(CW)) u_trk (
    .clk(clk), .rst(rst), .start(start), .adv(adv), .mf_octets(mf_octets),
    .pos(pos), .mf_idx(mf_idx), .at_last(at_last)
  );

  lac_rec_decode u_dec (.rec(rec), .cfg(dec), .sum(sum));

  lac_param_cmp u_cmp (.got(rec), .expv(rec_t'(exp_rec)), .mismatch(mism));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_SEARCH;
      rec         <= '0;
      cfg_q       <= '0;
      done        <= 1'b0;
      cfg_valid   <= 1'b0;
      err_start   <= 1'b0;
      err_end     <= 1'b0;
      err_cfgmark <= 1'b0;
      err_sum     <= 1'b0;
      err_param   <= 1'b0;
      err_len     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_SEARCH: if (start) state <= ST_RUN;
        ST_RUN: if (in_valid) begin
          if (pos == '0) begin
            if (!is_start) begin
              state     <= ST_FIN;
              done      <= 1'b1;
              cfg_valid <= 1'b1;
              cfg_q     <= dec;
              if (mf_idx < CW'(MF_MIN) || mf_idx > CW'(MF_MAX)) err_len <= 1'b1;
              if (mf_idx >= CW'(2)) begin
                if (sum != rec[SUM_IDX]) err_sum <= 1'b1;
                if (mism) err_param <= 1'b1;
              end
            end
          end else begin
            if (at_last) begin
              if (!is_end) err_end <= 1'b1;
            end else if (is_end) begin
              err_end <= 1'b1;
            end
            if (mf_idx == CW'(1) && pos == PW'(1)) begin
              if (!is_cfg) err_cfgmark <= 1'b1;
            end else if (is_cfg) begin
              err_cfgmark <= 1'b1;
            end
            if (is_start) err_start <= 1'b1;
            if (in_rec) rec[rofs[RIW-1:0]] <= in_data;
          end
        end
        default: ;
      endcase
    end
  end

  assign dev_id      = cfg_q.dev_id;
  assign bank_id     = cfg_q.bank_id;
  assign adj_steps   = cfg_q.adj_steps;
  assign adj_delay   = cfg_q.adj_delay;
  assign phase_req   = cfg_q.phase_req;
  assign lane_id     = cfg_q.lane_id;
  assign scramble    = cfg_q.scramble;
  assign lane_cnt    = cfg_q.lane_cnt;
  assign frame_len   = cfg_q.frame_len;
  assign mf_len      = cfg_q.mf_len;
  assign conv_cnt    = cfg_q.conv_cnt;
  assign ctl_bits    = cfg_q.ctl_bits;
  assign conv_res    = cfg_q.conv_res;
  assign subclass    = cfg_q.subclass;
  assign sample_bits = cfg_q.sample_bits;
  assign version     = cfg_q.version;
  assign spc         = cfg_q.spc;
  assign hi_density  = cfg_q.hi_density;
  assign ctl_words   = cfg_q.ctl_words;

  // R9: completion strobe lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: decoded outputs hold once valid
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> cfg_valid && $stable(conv_cnt) && $stable(dev_id));
  // R11: marker flags are sticky
  a_r11_sticky_marks: assert property (@(posedge clk) disable iff (rst)
    (err_start || err_end || err_cfgmark) |=>
      ($past(err_start) -> err_start) && ($past(err_end) -> err_end)
      && ($past(err_cfgmark) -> err_cfgmark));
  // R10: length error appears only with the completion strobe
  a_r10_len_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_len) |-> done);
  // R7: checksum error appears only with the completion strobe
  a_r7_sum_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_sum) |-> done);
  // R8: parameter error appears only with the completion strobe
  a_r8_param_at_done: assert property (@(posedge clk) disable iff (rst)
    $rose(err_param) |-> done);
endmodule

// File: tb/tb_lane_align_chk.sv
module tb_lane_align_chk;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ctrl;
  logic [7:0]   in_data;
  logic [8:0]   frm_octets;
  logic [5:0]   mf_frames;
  logic [111:0] exp_rec;
  logic done, cfg_valid, err_start, err_end, err_cfgmark, err_sum, err_param, err_len;
  logic [7:0] dev_id; logic [3:0] bank_id, adj_steps; logic adj_delay, phase_req;
  logic [4:0] lane_id; logic scramble; logic [5:0] lane_cnt; logic [8:0] frame_len;
  logic [5:0] mf_len; logic [8:0] conv_cnt; logic [1:0] ctl_bits; logic [5:0] conv_res;
  logic [2:0] subclass; logic [5:0] sample_bits; logic [2:0] version; logic [5:0] spc;
  logic hi_density; logic [4:0] ctl_words;

  int n_chk = 0, n_bad = 0;
  localparam int MFO = 20;  // 2 octets x 10 frames

  always #5 clk = ~clk;

  lane_align_chk dut (.*);

  // Raw field values of the test record
  localparam logic [7:0] F_DID = 8'hA5, F_F = 8'd1, F_M = 8'd255;
  localparam logic [3:0] F_ADJ = 4'd3, F_BANK = 4'd9;
  localparam logic [4:0] F_LID = 5'h13, F_L = 5'd3, F_K = 5'd9, F_N = 5'd15,
                         F_NP = 5'd15, F_S = 5'd0, F_CF = 5'd0;
  localparam logic [1:0] F_CS = 2'd2;
  localparam logic [2:0] F_SUB = 3'd1, F_VER = 3'd1;

  function automatic logic [7:0] field_sum();
    return F_DID + 8'(F_ADJ) + 8'(F_BANK) + 8'd1 + 8'd0 + 8'(F_LID) + 8'd1 + 8'(F_L)
         + F_F + 8'(F_K) + F_M + 8'(F_CS) + 8'(F_N) + 8'(F_SUB) + 8'(F_NP)
         + 8'(F_VER) + 8'(F_S) + 8'd1 + 8'(F_CF);
  endfunction

  // junk = 1 sets unused bits and reserved octets
  function automatic logic [111:0] mk_rec(input logic junk, input logic [7:0] chk);
    logic [13:0][7:0] r;
    r[0]  = F_DID;
    r[1]  = {F_ADJ, F_BANK};
    r[2]  = {junk, 1'b1, 1'b0, F_LID};
    r[3]  = {1'b1, junk, junk, F_L};
    r[4]  = F_F;
    r[5]  = {{3{junk}}, F_K};
    r[6]  = F_M;
    r[7]  = {F_CS, junk, F_N};
    r[8]  = {F_SUB, F_NP};
    r[9]  = {F_VER, F_S};
    r[10] = {1'b1, junk, junk, F_CF};
    r[11] = junk ? 8'h5A : 8'h00;
    r[12] = junk ? 8'hC3 : 8'h00;
    r[13] = chk;
    return r;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic put(input logic c, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_ctrl = c; in_data = d;
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; in_ctrl = 1'b0; in_data = 8'h00;
    frm_octets = 9'd2; mf_frames = 6'd10;
    exp_rec = mk_rec(1'b0, 8'h00);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // mode: 0 good, 1 no end marker in mf 2, 2 no record marker,
  //       3 stray start marker at mf 2 pos 5, 4 stray end marker at mf 2 pos 6
  task automatic send_seq(input int nmf, input int mode, input logic [111:0] rec);
    logic [13:0][7:0] r;
    r = rec;
    for (int m = 0; m < nmf; m++) begin
      for (int p = 0; p < MFO; p++) begin
        if (p == 0) put(1'b1, 8'h1C);
        else if (p == MFO-1 && !(mode == 1 && m == 2)) put(1'b1, 8'h7C);
        else if (m == 1 && p == 1 && mode != 2) put(1'b1, 8'h9C);
        else if (m == 1 && p >= 2 && p < 16) put(1'b0, r[p-2]);
        else if (mode == 3 && m == 2 && p == 5) put(1'b1, 8'h1C);
        else if (mode == 4 && m == 2 && p == 6) put(1'b1, 8'h7C);
        else put(1'b0, 8'((m * 7 + p) | 1));
      end
    end
    put(1'b0, 8'h42);  // first user data octet at a boundary
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic flags(input string req, input int s, input int e, input int c,
                       input int k, input int p, input int l);
    check({req, " err_start"}, err_start, s);
    check({req, " err_end"}, err_end, e);
    check({req, " err_cfgmark"}, err_cfgmark, c);
    check({req, " err_sum"}, err_sum, k);
    check({req, " err_param"}, err_param, p);
    check({req, " err_len"}, err_len, l);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1 done at reset", done, 0);
    check("R1 cfg_valid at reset", cfg_valid, 0);
    check("R1 conv_cnt at reset", conv_cnt, 0);
    flags("R1 reset", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_search();
    do_reset();
    put(1'b0, 8'h1C); put(1'b1, 8'hBC); put(1'b0, 8'h7C); put(1'b1, 8'h7C);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check("R1 no start on unflagged octets", done, 0);
    flags("R1 search ignores", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_good();
    do_reset();
    exp_rec = mk_rec(1'b0, 8'h00);
    put(1'b0, 8'h1C);  // unflagged 0x1C before the sequence: ignored (R1)
    send_seq(4, 0, mk_rec(1'b1, field_sum()));
    check("R9 done one cycle after boundary", done, 1);
    check("R9 cfg_valid", cfg_valid, 1);
    flags("R7 R8 R10 good sequence", 0, 0, 0, 0, 0, 0);
    check("R6 dev_id", dev_id, 8'hA5);
    check("R6 bank_id", bank_id, 9);
    check("R6 adj_steps", adj_steps, 3);
    check("R6 adj_delay", adj_delay, 1);
    check("R6 phase_req", phase_req, 0);
    check("R6 lane_id", lane_id, 5'h13);
    check("R6 scramble", scramble, 1);
    check("R6 lane_cnt", lane_cnt, 4);
    check("R6 frame_len", frame_len, 2);
    check("R6 mf_len", mf_len, 10);
    check("R6 conv_cnt", conv_cnt, 256);
    check("R6 ctl_bits", ctl_bits, 2);
    check("R6 conv_res", conv_res, 16);
    check("R6 subclass", subclass, 1);
    check("R6 sample_bits", sample_bits, 16);
    check("R6 version", version, 1);
    check("R6 spc", spc, 1);
    check("R6 hi_density", hi_density, 1);
    check("R6 ctl_words", ctl_words, 0);
    @(negedge clk);
    check("R9 done falls", done, 0);
    check("R9 cfg_valid holds", cfg_valid, 1);
    check("R5 R6 outputs hold", dev_id, 8'hA5);
  endtask

  task automatic t_sum();
    do_reset();
    exp_rec = mk_rec(1'b0, 8'h00);
    send_seq(4, 0, mk_rec(1'b0, field_sum() + 8'd1));
    check("R7 done", done, 1);
    flags("R7 bad checksum", 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_param();
    do_reset();
    exp_rec = mk_rec(1'b0, 8'h00);
    exp_rec[7:0] = 8'hA4;  // expected device id differs
    send_seq(5, 0, mk_rec(1'b0, field_sum()));
    flags("R8 device id differs", 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    check("R11 err_param sticky", err_param, 1);
  endtask

  task automatic t_marks(input int mode);
    do_reset();
    send_seq(4, mode, mk_rec(1'b0, field_sum()));
    case (mode)
      1: flags("R2 missing end marker", 0, 1, 0, 0, 0, 0);
      2: flags("R4 missing record marker", 0, 0, 1, 0, 0, 0);
      3: flags("R3 stray start marker", 1, 0, 0, 0, 0, 0);
      default: flags("R2 stray end marker", 0, 1, 0, 0, 0, 0);
    endcase
  endtask

  task automatic t_len(input int nmf, input int bad);
    do_reset();
    send_seq(nmf, 0, mk_rec(1'b0, field_sum()));
    check($sformatf("R10 done for %0d multiframes", nmf), done, 1);
    check($sformatf("R10 err_len for %0d multiframes", nmf), err_len, bad);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_search();
        t_good();
        t_sum();
        t_param();
        t_marks(1);
        t_marks(2);
        t_marks(3);
        t_marks(4);
        t_len(3, 1);
        t_len(256, 0);
        t_len(257, 1);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule